// File: doc/BRIEF.md
# Four-Register Datapath Slice with Sixteen-Function ALU

This block is the arithmetic heart of a small 8-bit processor: a bank of four general registers, an ALU that decodes sixteen arithmetic and sixteen logic functions, a carry flag, and a shared internal data bus. A controller steers it with select lines and enables, and the clock edge is the write strobe for the whole slice.

The bus has two possible sources: an external operand input or the ALU result. The bus is modelled as a priority multiplexer, not as tristate drivers. The destination select does two jobs. It names the register that captures the bus on a write edge, and it also names the register that feeds ALU operand A. A separate source select names the register on operand B. Read-modify-write instructions such as "R0 = R0 + R1" therefore take one clock: the result is on the bus during the cycle and lands in the destination register at the edge.

The ALU follows the classic 4-bit-select function map with a mode bit. Its carry-in and carry-out are both active low, so "no carry" is a 1 on both. Addition and subtraction each depend on a particular combination of mode, select and carry-in.

Top module: `rfa_slice`

## Requirements
- R1: The bus carries `ext_data` whenever `ext_drive` is 1, even if `alu_drive` is also 1. With only `alu_drive` set, the bus carries the ALU result. With neither set, the bus reads 00h.
- R2: On a rising clock edge with `wr_en` = 1, the register indexed by `dst_sel` takes the bus value and the other registers keep their values. With `wr_en` = 0, no register changes.
- R3: ALU operand A is the register indexed by `dst_sel`, and operand B is the register indexed by `src_sel`. The two selects may name the same register.
- R4: Logic mode (`logic_mode` = 1) produces, for `fsel` values 0 to 15: ~A, ~(A|B), ~A&B, 00h, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, FFh, A|~B, A|B, A. In this mode the carry input is ignored.
- R5: Arithmetic mode (`logic_mode` = 0) produces X+Y+c, truncated to 8 bits, where c = 1 when `carry_in_n` = 0 and c = 0 when it is 1. The pair (X,Y) for `fsel` 0 to 15 is: (A,0), (A|B,0), (A|~B,0), (0,FFh), (A,A&~B), (A|B,A&~B), (A,~B), (A&~B,FFh), (A,A&B), (A,B), (A|~B,A&B), (A&B,FFh), (A,A), (A|B,A), (A|~B,A), (A,FFh).
- R6: Code 1001 with `carry_in_n` = 1 adds, giving A+B. Code 0110 with `carry_in_n` = 0 subtracts, giving A−B. Both are in arithmetic mode.
- R7: The ALU carry-out is active low. In arithmetic mode it is 0 exactly when X+Y+c exceeds FFh. In logic mode it is 1.
- R8: On a rising edge with `carry_load` = 1, `carry_flag` takes the ALU carry-out. With `carry_load` = 0, it holds its value.
- R9: While `rst_n` is low, every register clears to 00h and `carry_flag` is set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write strobe; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| dst_sel | input | 2 | Destination register and operand A select |
| src_sel | input | 2 | Operand B select |
| ext_data | input | 8 | External operand for the bus |
| ext_drive | input | 1 | Put ext_data on the bus (highest priority) |
| alu_drive | input | 1 | Put the ALU result on the bus |
| logic_mode | input | 1 | 1 = logic functions, 0 = arithmetic |
| fsel | input | 4 | ALU function code |
| carry_in_n | input | 1 | Active-low carry-in |
| carry_load | input | 1 | Load the carry flag at the edge |
| bus_out | output | 8 | Current bus value |
| carry_flag | output | 1 | Registered active-low carry |

## Verification
The assertions assume that select and control inputs are stable around the rising edge and are never unknown outside reset. The bench meets this by changing every input only on the falling edge and keeping each value until the next falling edge. The write and flag properties also assume that the bus value sampled at an edge is the value that was written. This holds because the bus is purely combinational from registers and inputs that do not move at the edge. Register contents are observed only through the bus: the bench selects logic function 15 (pass A) or 10 (pass B) to read a register back.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

    // bus source after priority resolution
    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_EXT  = 2'd1,
        BUS_ALU  = 2'd2
    } bus_src_e;

    // arithmetic function codes that the slice treats specially in checks
    typedef enum logic [3:0] {
        FN_SUB_MINUS1 = 4'b0110,
        FN_ADD        = 4'b1001,
        FN_PASS_B     = 4'b1010,
        FN_PASS_A     = 4'b1111
    } fn_code_e;

    typedef struct packed {
        logic carry_n;
    } flag_state_t;

endpackage

// File: rtl/rfa_regfile.sv
module rfa_regfile #(
    parameter int WIDTH = 8,
    parameter int NREG  = 4,
    localparam int SELW = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SELW-1:0]            wsel,
    input  logic [WIDTH-1:0]           wdata,
    output logic [NREG-1:0][WIDTH-1:0] regs_q
);

    logic [NREG-1:0][WIDTH-1:0] regs_d;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        always_comb begin
            regs_d[gi] = regs_q[gi];
            if (we && (wsel == SELW'(gi))) begin
                regs_d[gi] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/rfa_alu.sv
module rfa_alu #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             logic_mode,
    input  logic [3:0]       fsel,
    input  logic             carry_in_n,
    output logic [WIDTH-1:0] f,
    output logic             carry_out_n
);

    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] lf;
    logic [WIDTH-1:0] op_x;
    logic [WIDTH-1:0] op_y;
    logic [WIDTH:0]   sum;

    // logic functions
    always_comb begin
        unique case (fsel)
            4'd0:  lf = ~a;
            4'd1:  lf = ~(a | b);
            4'd2:  lf = ~a & b;
            4'd3:  lf = ZERO;
            4'd4:  lf = ~(a & b);
            4'd5:  lf = ~b;
            4'd6:  lf = a ^ b;
            4'd7:  lf = a & ~b;
            4'd8:  lf = ~a | b;
            4'd9:  lf = ~(a ^ b);
            4'd10: lf = b;
            4'd11: lf = a & b;
            4'd12: lf = ONES;
            4'd13: lf = a | ~b;
            4'd14: lf = a | b;
            default: lf = a;
        endcase
    end

    // arithmetic functions: every code is an addition of two terms
    always_comb begin
        unique case (fsel)
            4'd0:  begin op_x = a;          op_y = ZERO;     end
            4'd1:  begin op_x = a | b;      op_y = ZERO;     end
            4'd2:  begin op_x = a | ~b;     op_y = ZERO;     end
            4'd3:  begin op_x = ZERO;       op_y = ONES;     end
            4'd4:  begin op_x = a;          op_y = a & ~b;   end
            4'd5:  begin op_x = a | b;      op_y = a & ~b;   end
            4'd6:  begin op_x = a;          op_y = ~b;       end
            4'd7:  begin op_x = a & ~b;     op_y = ONES;     end
            4'd8:  begin op_x = a;          op_y = a & b;    end
            4'd9:  begin op_x = a;          op_y = b;        end
            4'd10: begin op_x = a | ~b;     op_y = a & b;    end
            4'd11: begin op_x = a & b;      op_y = ONES;     end
            4'd12: begin op_x = a;          op_y = a;        end
            4'd13: begin op_x = a | b;      op_y = a;        end
            4'd14: begin op_x = a | ~b;     op_y = a;        end
            default: begin op_x = a;        op_y = ONES;     end
        endcase
    end

    assign sum = {1'b0, op_x} + {1'b0, op_y} + {{WIDTH{1'b0}}, ~carry_in_n};

    always_comb begin
        if (logic_mode) begin
            f           = lf;
            carry_out_n = 1'b1;
        end else begin
            f           = sum[WIDTH-1:0];
            carry_out_n = ~sum[WIDTH];
        end
    end

endmodule

// File: rtl/rfa_busmux.sv
module rfa_busmux #(
    parameter int WIDTH = 8
) (
    input  logic             ext_drive,
    input  logic             alu_drive,
    input  logic [WIDTH-1:0] ext_data,
    input  logic [WIDTH-1:0] alu_data,
    output logic [WIDTH-1:0] bus
);
    import rfa_pkg::*;

    bus_src_e src;

    always_comb begin
        if (ext_drive)      src = BUS_EXT;
        else if (alu_drive) src = BUS_ALU;
        else                src = BUS_IDLE;
    end

    always_comb begin
        unique case (src)
            BUS_EXT: bus = ext_data;
            BUS_ALU: bus = alu_data;
            default: bus = '0;
        endcase
    end

endmodule

// File: rtl/rfa_slice.sv
module rfa_slice #(
    parameter int WIDTH = 8,
    parameter int NREG  = 4,
    localparam int SELW = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SELW-1:0]  dst_sel,
    input  logic [SELW-1:0]  src_sel,
    input  logic [WIDTH-1:0] ext_data,
    input  logic             ext_drive,
    input  logic             alu_drive,
    input  logic             logic_mode,
    input  logic [3:0]       fsel,
    input  logic             carry_in_n,
    input  logic             carry_load,
    output logic [WIDTH-1:0] bus_out,
    output logic             carry_flag
);
    import rfa_pkg::*;

    logic [NREG-1:0][WIDTH-1:0] regs;
    logic [WIDTH-1:0]           opnd_a;
    logic [WIDTH-1:0]           opnd_b;
    logic [WIDTH-1:0]           alu_f;
    logic                       alu_cout_n;
    logic [WIDTH-1:0]           bus;
    flag_state_t                flag_d;
    flag_state_t                flag_q;

    rfa_regfile #(.WIDTH(WIDTH), .NREG(NREG)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .wsel   (dst_sel),
        .wdata  (bus),
        .regs_q (regs)
    );

    always_comb begin
        opnd_a = regs[dst_sel];
        opnd_b = regs[src_sel];
    end

    rfa_alu #(.WIDTH(WIDTH)) u_alu (
        .a           (opnd_a),
        .b           (opnd_b),
        .logic_mode  (logic_mode),
        .fsel        (fsel),
        .carry_in_n  (carry_in_n),
        .f           (alu_f),
        .carry_out_n (alu_cout_n)
    );

    rfa_busmux #(.WIDTH(WIDTH)) u_bus (
        .ext_drive (ext_drive),
        .alu_drive (alu_drive),
        .ext_data  (ext_data),
        .alu_data  (alu_f),
        .bus       (bus)
    );

    always_comb begin
        flag_d = flag_q;
        if (carry_load) begin
            flag_d.carry_n = alu_cout_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q.carry_n <= 1'b1;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign bus_out    = bus;
    assign carry_flag = flag_q.carry_n;

endmodule

// File: rtl/rfa_slice_chk.sv
module rfa_slice_chk #(
    parameter int WIDTH = 8,
    parameter int NREG  = 4,
    localparam int SELW = $clog2(NREG)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [SELW-1:0]            dst_sel,
    input logic [WIDTH-1:0]           ext_data,
    input logic                       ext_drive,
    input logic                       alu_drive,
    input logic                       logic_mode,
    input logic [3:0]                 fsel,
    input logic                       carry_in_n,
    input logic                       carry_load,
    input logic [WIDTH-1:0]           bus_out,
    input logic                       carry_flag,
    input logic [NREG-1:0][WIDTH-1:0] regs,
    input logic [WIDTH-1:0]           opnd_a,
    input logic [WIDTH-1:0]           opnd_b,
    input logic [WIDTH-1:0]           alu_f,
    input logic                       alu_cout_n
);

    AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_drive |-> bus_out == ext_data); // R1

    AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_drive && !alu_drive) |-> bus_out == '0); // R1

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> regs == $past(regs)); // R2

    AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(dst_sel)] == $past(bus_out)); // R2

    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!logic_mode && fsel == 4'b1001 && carry_in_n) |-> alu_f == WIDTH'(opnd_a + opnd_b)); // R6

    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!logic_mode && fsel == 4'b0110 && !carry_in_n) |-> alu_f == WIDTH'(opnd_a - opnd_b)); // R6

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        logic_mode |-> alu_cout_n); // R7

    AST_CARRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        carry_load |=> carry_flag == $past(alu_cout_n)); // R8

    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_load |=> $stable(carry_flag)); // R8

endmodule

bind rfa_slice rfa_slice_chk #(.WIDTH(WIDTH), .NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .dst_sel    (dst_sel),
    .ext_data   (ext_data),
    .ext_drive  (ext_drive),
    .alu_drive  (alu_drive),
    .logic_mode (logic_mode),
    .fsel       (fsel),
    .carry_in_n (carry_in_n),
    .carry_load (carry_load),
    .bus_out    (bus_out),
    .carry_flag (carry_flag),
    .regs       (regs),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .alu_f      (alu_f),
    .alu_cout_n (alu_cout_n)
);

// File: tb/rfa_slice_tb.sv
module rfa_slice_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] dst_sel = '0;
    logic [1:0] src_sel = '0;
    logic [7:0] ext_data = '0;
    logic       ext_drive = 1'b0;
    logic       alu_drive = 1'b0;
    logic       logic_mode = 1'b0;
    logic [3:0] fsel = '0;
    logic       carry_in_n = 1'b1;
    logic       carry_load = 1'b0;
    logic [7:0] bus_out;
    logic       carry_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    rfa_slice u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .dst_sel    (dst_sel),
        .src_sel    (src_sel),
        .ext_data   (ext_data),
        .ext_drive  (ext_drive),
        .alu_drive  (alu_drive),
        .logic_mode (logic_mode),
        .fsel       (fsel),
        .carry_in_n (carry_in_n),
        .carry_load (carry_load),
        .bus_out    (bus_out),
        .carry_flag (carry_flag)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // expected ALU result and active-low carry, from the function tables
    task automatic model(input logic [7:0] a, input logic [7:0] b, input logic m,
                         input logic [3:0] s, input logic cn,
                         output logic [7:0] f, output logic con);
        logic [7:0] x, y;
        int         total;
        if (m) begin
            case (s)
                4'd0: f = ~a;          4'd1: f = ~(a | b);
                4'd2: f = ~a & b;      4'd3: f = 8'h00;
                4'd4: f = ~(a & b);    4'd5: f = ~b;
                4'd6: f = a ^ b;       4'd7: f = a & ~b;
                4'd8: f = ~a | b;      4'd9: f = ~(a ^ b);
                4'd10: f = b;          4'd11: f = a & b;
                4'd12: f = 8'hFF;      4'd13: f = a | ~b;
                4'd14: f = a | b;      default: f = a;
            endcase
            con = 1'b1;
        end else begin
            case (s)
                4'd0: begin x = a; y = 0; end
                4'd1: begin x = a | b; y = 0; end
                4'd2: begin x = a | ~b; y = 0; end
                4'd3: begin x = 0; y = 8'hFF; end
                4'd4: begin x = a; y = a & ~b; end
                4'd5: begin x = a | b; y = a & ~b; end
                4'd6: begin x = a; y = ~b; end
                4'd7: begin x = a & ~b; y = 8'hFF; end
                4'd8: begin x = a; y = a & b; end
                4'd9: begin x = a; y = b; end
                4'd10: begin x = a | ~b; y = a & b; end
                4'd11: begin x = a & b; y = 8'hFF; end
                4'd12: begin x = a; y = a; end
                4'd13: begin x = a | b; y = a; end
                4'd14: begin x = a | ~b; y = a; end
                default: begin x = a; y = 8'hFF; end
            endcase
            total = int'(x) + int'(y) + (cn ? 0 : 1);
            f   = total[7:0];
            con = (total > 255) ? 1'b0 : 1'b1;
        end
    endtask

    task automatic idle_ctrl();
        wr_en = 0; ext_drive = 0; alu_drive = 0; carry_load = 0;
    endtask

    task automatic load_reg(input logic [1:0] r, input logic [7:0] v);
        @(negedge clk);
        idle_ctrl();
        ext_drive = 1; ext_data = v; dst_sel = r; wr_en = 1;
        @(negedge clk);
        idle_ctrl();
    endtask

    // read a register back through the bus using logic pass-A
    task automatic read_reg(input logic [1:0] r, output logic [7:0] v);
        @(negedge clk);
        idle_ctrl();
        alu_drive = 1; logic_mode = 1; fsel = 4'd15; dst_sel = r;
        #2 v = bus_out;
    endtask

    initial begin
        logic [7:0] rv, ef;
        logic       ec;
        logic [7:0] pa [6] = '{8'h55, 8'h00, 8'hFF, 8'h80, 8'h07, 8'h3C};
        logic [7:0] pb [6] = '{8'hAA, 8'h00, 8'h01, 8'h80, 8'h01, 8'hC5};
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 flag", {7'd0, carry_flag}, 8'h01);
        rst_n = 1;
        for (int r = 0; r < 4; r++) begin
            read_reg(2'(r), rv);
            check("R9 reg", rv, 8'h00);
        end

        // R1 bus priority and idle value
        @(negedge clk);
        idle_ctrl();
        ext_data = 8'h5A; ext_drive = 1; alu_drive = 1; logic_mode = 1; fsel = 4'd12;
        #2 check("R1 ext priority", bus_out, 8'h5A);
        ext_drive = 0;
        #2 check("R1 alu drive", bus_out, 8'hFF);
        alu_drive = 0;
        #2 check("R1 idle", bus_out, 8'h00);

        // R2 write and ignored write
        load_reg(2'd3, 8'h3C);
        read_reg(2'd3, rv); check("R2 write", rv, 8'h3C);
        @(negedge clk);
        idle_ctrl(); ext_drive = 1; ext_data = 8'hE1; dst_sel = 2'd3; wr_en = 0;
        @(negedge clk);
        read_reg(2'd3, rv); check("R2 no write when disabled", rv, 8'h3C);
        read_reg(2'd2, rv); check("R2 neighbour untouched", rv, 8'h00);

        // R4 R5 R7 R8 sweep over operand pairs, modes, codes and carry-in
        for (int p = 0; p < 6; p++) begin
            load_reg(2'd1, pa[p]);
            load_reg(2'd2, pb[p]);
            for (int m = 0; m < 2; m++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int c = 0; c < 2; c++) begin
                        @(negedge clk);
                        idle_ctrl();
                        dst_sel = 2'd1; src_sel = 2'd2; alu_drive = 1;
                        logic_mode = 1'(m); fsel = 4'(s); carry_in_n = 1'(c);
                        carry_load = 1;
                        model(pa[p], pb[p], 1'(m), 4'(s), 1'(c), ef, ec);
                        #2 check(m ? "R4 logic fn" : "R5 arith fn", bus_out, ef);
                        @(negedge clk);
                        carry_load = 0;
                        check("R7 R8 carry", {7'd0, carry_flag}, {7'd0, ec});
                    end
                end
            end
        end

        // R8 hold: flag is 0 after FF+01 add, then a no-carry op without load
        load_reg(2'd0, 8'hFF);
        load_reg(2'd1, 8'h01);
        @(negedge clk);
        idle_ctrl(); dst_sel = 0; src_sel = 1; alu_drive = 1; logic_mode = 0;
        fsel = 4'b1001; carry_in_n = 1; carry_load = 1;
        @(negedge clk);
        check("R8 load carry", {7'd0, carry_flag}, 8'h00);
        carry_load = 0; logic_mode = 1;
        @(negedge clk);
        check("R8 hold", {7'd0, carry_flag}, 8'h00);

        // R6 R3: accumulate R0 = R0 + R1 twice, then subtract
        load_reg(2'd0, 8'h07);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            idle_ctrl(); dst_sel = 0; src_sel = 1; alu_drive = 1; logic_mode = 0;
            fsel = 4'b1001; carry_in_n = 1; wr_en = 1;
        end
        read_reg(2'd0, rv); check("R6 add writeback", rv, 8'h09);
        @(negedge clk);
        idle_ctrl(); dst_sel = 0; src_sel = 1; alu_drive = 1; logic_mode = 0;
        fsel = 4'b0110; carry_in_n = 0; wr_en = 1;
        read_reg(2'd0, rv); check("R6 subtract writeback", rv, 8'h08);
        // R3 operand B from src_sel via pass-B, and same register on both
        @(negedge clk);
        idle_ctrl(); dst_sel = 0; src_sel = 1; alu_drive = 1; logic_mode = 1; fsel = 4'd10;
        #2 check("R3 operand B", bus_out, 8'h01);
        src_sel = 0; logic_mode = 0; fsel = 4'b1001; carry_in_n = 1;
        #2 check("R3 same register", bus_out, 8'h10);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule